// File: doc/BRIEF.md
# Page Map Entry Flag Manager

This block owns a table of page map entries, one per virtual page, and serves three commands on it: write a whole entry (set map), replace only the flag field while reporting the previous contents (set flags), and report the contents without touching them (get flags). Each entry is a 16-bit word that packs a 12-bit real page number with its two bytes exchanged, a 3-bit flag field and a derived status bit. The status bit marks the flag values 2, 3 and 7.

A command is offered on a single port together with its virtual page, real page and flag operands. Every accepted command takes the same number of cycles: two busy cycles, then a one-cycle done pulse on which the results of a flag command become visible. The table sits in an internal synchronous RAM with a registered read, backed by one valid bit per entry, so the whole table reads as zero after reset without a clearing sweep. The flag value 6 marks a vacant page. A set flags command cannot take a page out of that state.

Top module: `pmf_map_unit`

## Requirements
- R1: After reset busy and done are low, the three result outputs are zero, and every table entry reads back as the all-zero word.
- R2: The table index is the low 8 bits of the virtual page operand after its two bytes are exchanged, that is, cmd_vpage[15:8]. The low byte of the operand does not select an entry.
- R3: An entry word holds real page bits 7:0 in word bits 15:8, real page bits 11:8 in word bits 3:0, the flags in word bits 6:4 and the status bit in word bit 7. Real page operand bits 15:12 are dropped.
- R4: Only the low 3 bits of the flag operand are used. Its upper 13 bits are ignored.
- R5: Every write sets word bit 7 when the written flag value is 2, 3 or 7, and clears it for 0, 1, 4, 5 and 6.
- R6: Set flags keeps the stored real page field and writes the requested flags.
- R7: When the stored flags equal 6 (vacant), set flags writes flag value 6 whatever value was requested.
- R8: Set flags and get flags report the previous entry on res_word, its flags on res_flags and its real page on res_page as {4'b0, word[3:0], word[15:8]}. Get flags never changes the table.
- R9: Set map leaves res_word, res_flags and res_page unchanged.
- R10: A command is accepted at a clock edge where cmd_valid is high and busy is low. Busy is then high for two cycles, and done is high for exactly the one cycle that follows. A new command may be accepted during that done cycle.
- R11: Commands offered while busy is high are ignored. The op code 2'b11 is never accepted. Op codes are 2'b00 set map, 2'b01 set flags and 2'b10 get flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | 00 set map, 01 set flags, 10 get flags, 11 none |
| cmd_vpage | input | 16 | Virtual page operand; bits 15:8 select the entry |
| cmd_rpage | input | 16 | Real page operand; bits 11:0 are kept |
| cmd_flags | input | 16 | Flag operand; bits 2:0 are used |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_flags | output | 3 | Previous flags of the addressed entry |
| res_page | output | 16 | Previous real page of the addressed entry |
| res_word | output | 16 | Previous whole entry word |

## Verification
The case where two commands overlap is a completion that writes an entry in the same cycle in which the next command is accepted, and that next command then reads the entry just written. The bench provokes this by holding cmd_valid high across a set map and then switching the operands to a get flags on the same page. The get is accepted on the done cycle and must report the freshly written word. Commands changed while busy must leave no trace. A behavioural model of the table and of the three-cycle timing runs next to the design, including long stretches of random back-to-back traffic on a few shared pages, and judges every output on every clock.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  localparam int WORD_W = 16;
  localparam int FLAG_W = 3;
  localparam int PAGE_W = 12;
  localparam logic [FLAG_W-1:0] FLAGS_VACANT = 3'd6;

  typedef enum logic [1:0] {
    OP_SET_MAP = 2'b00,
    OP_SET_FLG = 2'b01,
    OP_GET_FLG = 2'b10,
    OP_NONE    = 2'b11
  } pmf_op_e;

  function automatic logic status_of(input logic [FLAG_W-1:0] f);
    return (f == 3'd2) || (f == 3'd3) || (f == 3'd7);
  endfunction

  function automatic logic [WORD_W-1:0] pack_entry(input logic [PAGE_W-1:0] page,
                                                   input logic [FLAG_W-1:0] f);
    return {page[7:0], status_of(f), f, page[11:8]};
  endfunction

  function automatic logic [PAGE_W-1:0] entry_page(input logic [WORD_W-1:0] w);
    return {w[3:0], w[15:8]};
  endfunction

  function automatic logic [FLAG_W-1:0] entry_flags(input logic [WORD_W-1:0] w);
    return w[6:4];
  endfunction
endpackage

// File: rtl/pmf_store.sv
module pmf_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live;
  logic [DATA_W-1:0] q_raw;
  logic              q_live;

  // RAM body: no reset, registered read, so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (rd_en) q_raw <= mem[addr];
  end

  // Per-entry valid bits give the all-zero table after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      q_live <= 1'b0;
    end else begin
      if (we) live[addr] <= 1'b1;
      if (rd_en) q_live <= live[addr];
    end
  end

  assign rdata = q_live ? q_raw : '0;

  assert_no_rw_clash_R10: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && we));
endmodule

// File: rtl/pmf_entry_fmt.sv
module pmf_entry_fmt
  import pmf_pkg::*;
(
  input  pmf_op_e           op,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [FLAG_W-1:0] req_flags,
  input  logic [WORD_W-1:0] old_word,
  output logic [WORD_W-1:0] new_word,
  output logic [FLAG_W-1:0] old_flags,
  output logic [PAGE_W-1:0] old_page
);
  logic [FLAG_W-1:0] kept_flags;

  assign old_flags  = entry_flags(old_word);
  assign old_page   = entry_page(old_word);
  assign kept_flags = (old_flags == FLAGS_VACANT) ? FLAGS_VACANT : req_flags;

  always_comb begin
    if (op == OP_SET_MAP) new_word = pack_entry(req_page, req_flags);
    else                  new_word = pack_entry(old_page, kept_flags);
  end
endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [15:0]       cmd_vpage,
  input  logic [15:0]       cmd_rpage,
  input  logic [15:0]       cmd_flags,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [FLAG_W-1:0] old_flags,
  input  logic [PAGE_W-1:0] old_page,
  output pmf_op_e           op_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [FLAG_W-1:0] flags_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_rd,
  output logic              ram_we,
  output logic              busy,
  output logic              done,
  output logic [FLAG_W-1:0] res_flags,
  output logic [15:0]       res_page,
  output logic [15:0]       res_word
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} st_e;
  st_e state;

  logic [15:0] vrot;
  logic        accept;
  logic        unused_bits;

  assign vrot        = {cmd_vpage[7:0], cmd_vpage[15:8]};
  assign unused_bits = ^{vrot, cmd_rpage[15:PAGE_W], cmd_flags[15:FLAG_W]};
  assign accept      = (state == ST_IDLE) && cmd_valid && (pmf_op_e'(cmd_op) != OP_NONE);
  assign ram_rd      = (state == ST_READ);
  assign ram_we      = (state == ST_WRITE) && (op_q != OP_GET_FLG);
  assign busy        = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_NONE;
      page_q    <= '0;
      flags_q   <= '0;
      ram_addr  <= '0;
      done      <= 1'b0;
      res_flags <= '0;
      res_page  <= '0;
      res_word  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q     <= pmf_op_e'(cmd_op);
          ram_addr <= vrot[ADDR_W-1:0];
          page_q   <= cmd_rpage[PAGE_W-1:0];
          flags_q  <= cmd_flags[FLAG_W-1:0];
          state    <= ST_READ;
        end
        ST_READ: state <= ST_WRITE;
        default: begin
          if (op_q != OP_SET_MAP) begin
            res_word  <= rd_word;
            res_flags <= old_flags;
            res_page  <= {{(16-PAGE_W){1'b0}}, old_page};
          end
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(busy, 2) && !busy));
  assert_busy_holds_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(op_q) && $stable(ram_addr) && $stable(flags_q)));
  assert_vacant_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (ram_we && op_q == OP_SET_FLG && old_flags == FLAGS_VACANT) |-> new_word[6:4] == FLAGS_VACANT);
  assert_page_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (ram_we && op_q == OP_SET_FLG) |-> (new_word[15:8] == rd_word[15:8] && new_word[3:0] == rd_word[3:0]));
  assert_status_bit_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (new_word[7] == (new_word[6:4] == 3'd2 || new_word[6:4] == 3'd3 || new_word[6:4] == 3'd7)));
  assert_results_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_word) |-> done);
endmodule

// File: rtl/pmf_map_unit.sv
module pmf_map_unit
  import pmf_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [1:0]  cmd_op,
  input  logic [15:0] cmd_vpage,
  input  logic [15:0] cmd_rpage,
  input  logic [15:0] cmd_flags,
  output logic        busy,
  output logic        done,
  output logic [2:0]  res_flags,
  output logic [15:0] res_page,
  output logic [15:0] res_word
);
  pmf_op_e           op_q;
  logic [PAGE_W-1:0] page_q;
  logic [FLAG_W-1:0] flags_q;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_rd, ram_we;
  logic [WORD_W-1:0] rd_word, new_word;
  logic [FLAG_W-1:0] old_flags;
  logic [PAGE_W-1:0] old_page;

  pmf_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vpage(cmd_vpage), .cmd_rpage(cmd_rpage), .cmd_flags(cmd_flags),
    .rd_word(rd_word), .new_word(new_word), .old_flags(old_flags), .old_page(old_page),
    .op_q(op_q), .page_q(page_q), .flags_q(flags_q), .ram_addr(ram_addr),
    .ram_rd(ram_rd), .ram_we(ram_we), .busy(busy), .done(done),
    .res_flags(res_flags), .res_page(res_page), .res_word(res_word)
  );

  pmf_entry_fmt u_fmt (
    .op(op_q), .req_page(page_q), .req_flags(flags_q), .old_word(rd_word),
    .new_word(new_word), .old_flags(old_flags), .old_page(old_page)
  );

  pmf_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .rd_en(ram_rd), .addr(ram_addr),
    .we(ram_we), .wdata(new_word), .rdata(rd_word)
  );
endmodule

// File: tb/tb_pmf_map_unit.sv
`timescale 1ns/1ps
module tb_pmf_map_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b11;
  logic [15:0] cmd_vpage = '0, cmd_rpage = '0, cmd_flags = '0;
  logic busy, done;
  logic [2:0] res_flags;
  logic [15:0] res_page, res_word;

  always #2.5 clk = ~clk;

  pmf_map_unit dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_vpage(cmd_vpage), .cmd_rpage(cmd_rpage), .cmd_flags(cmd_flags),
    .busy(busy), .done(done), .res_flags(res_flags), .res_page(res_page), .res_word(res_word)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mem [256];
  int cnt = 0, m_op = 0, m_idx = 0, m_rp = 0, m_fl = 0;
  int e_busy = 0, e_done = 0, e_rf = 0, e_rp = 0, e_rw = 0;

  function automatic int mk(input int p, input int f);
    int st;
    st = (f == 2 || f == 3 || f == 7) ? 1 : 0;
    return ((p & 255) << 8) | (st << 7) | (f << 4) | ((p >> 8) & 15);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mem[i]) mem[i] = 0;
      cnt = 0; e_busy = 0; e_done = 0; e_rf = 0; e_rp = 0; e_rw = 0;
    end else begin
      e_done = 0;
      if (cnt == 0) begin
        if (cmd_valid && cmd_op != 2'b11) begin
          m_op = cmd_op; m_idx = (cmd_vpage >> 8) & 255;
          m_rp = cmd_rpage & 'hFFF; m_fl = cmd_flags & 7; cnt = 1;
        end
      end else if (cnt == 1) cnt = 2;
      else begin
        int old, of, op_;
        old = mem[m_idx]; of = (old >> 4) & 7; op_ = ((old & 15) << 8) | ((old >> 8) & 255);
        if (m_op == 0) mem[m_idx] = mk(m_rp, m_fl);
        else begin
          e_rw = old; e_rf = of; e_rp = op_;
          if (m_op == 1) mem[m_idx] = mk(op_, (of == 6) ? 6 : m_fl);
        end
        e_done = 1; cnt = 0;
      end
      e_busy = (cnt != 0) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      check("R1 busy at reset", busy, 0);
      check("R1 done at reset", done, 0);
      check("R1 res_word at reset", res_word, 0);
    end else begin
      check("R10 busy", busy, e_busy);
      check("R10 done", done, e_done);
      check("R8 res_flags", res_flags, e_rf);
      check("R8 res_page", res_page, e_rp);
      check("R3 res_word", res_word, e_rw);
    end
  end

  task automatic issue(input int op, input int vp, input int rp, input int fl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_vpage = vp[15:0];
    cmd_rpage = rp[15:0]; cmd_flags = fl[15:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: empty table reads zero
    issue(2, 'h0500, 0, 0);
    check("R1 empty entry word", res_word, 0);
    // R3 R4 R5: flags operand 0xFFFA masks to 2, page bits 15:12 dropped
    issue(0, 'h0512, 'hF3A7, 'hFFFA);
    check("R9 set map keeps results", res_word, 0);
    issue(2, 'h05FF, 0, 0);
    check("R3 packed word", res_word, 'hA7A3);
    check("R4 masked flags", res_flags, 2);
    check("R8 old page", res_page, 'h03A7);
    // R6: set flags to 6 keeps page, clears status bit
    issue(1, 'h0500, 'hFFFF, 6);
    check("R8 set flags returns old flags", res_flags, 2);
    issue(2, 'h0500, 0, 0);
    check("R6 page kept flags replaced", res_word, 'hA763);
    // R7: vacant stays vacant
    issue(1, 'h0500, 0, 1);
    check("R7 returns vacant", res_flags, 6);
    issue(2, 'h0500, 0, 0);
    check("R7 still vacant", res_word, 'hA763);
    // R5 flag 7 sets bit 7, flag 4 does not; R2 separate index
    issue(0, 'h0933, 'h0001, 7);
    issue(2, 'h0900, 0, 0);
    check("R5 status bit for 7", res_word, 'h01F0);
    issue(0, 'h0A00, 0, 4);
    issue(2, 'h0A77, 0, 0);
    check("R5 no status bit for 4", res_word, 'h0040);
    issue(2, 'h0501, 0, 0);
    check("R2 other index untouched", res_word, 'hA763);
    // R10 R11: held valid; changed operands while busy ignored, get accepted on done cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b00; cmd_vpage = 'h0700; cmd_rpage = 'h1234; cmd_flags = 3;
    @(negedge clk);
    cmd_op = 2'b10; cmd_vpage = 'h07AA;
    while (!done) @(negedge clk);
    @(negedge clk);
    while (!done) @(negedge clk);
    cmd_valid = 1'b0;
    check("R11 back-to-back read of new entry", res_word, 'h34B2);
    // R11: op 3 never accepted
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11;
    @(negedge clk);
    check("R11 op 3 ignored", busy, 0);
    cmd_valid = 1'b0;
    // Random traffic on a few pages
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cmd_valid = ($urandom % 3) != 0;
      cmd_op    = 2'($urandom);
      cmd_vpage = 16'({$urandom_range(0, 5), 8'($urandom)});
      cmd_rpage = 16'($urandom);
      cmd_flags = 16'($urandom);
    end
    cmd_valid = 1'b0;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule